// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

This block is the master side of a serial NOR flash port. A client presents one request (read, page program or sector erase) with a start byte address and a byte count. The block turns it into the series of serial bus frames the flash needs and raises `done` for one cycle when the whole request has finished, with `err` beside it if the request was refused or the flash stayed busy too long.

Every frame opens with a one-byte opcode, then, for the memory commands, three address bytes with the most significant byte first, then an optional data phase, all inside one chip-select window. The bus runs in SPI mode 0 with a programmable half-period. Program data is pulled from a byte stream input. Read data is pushed out on a byte stream with a valid strobe. Reads need no preparation. Every page program and every sector erase is preceded by its own write-enable frame and followed by status polling until the busy flag clears. Requests are checked for alignment and range before anything reaches the bus.

Sizes of the device, erase sector, program page and read chunk are parameters and must be powers of two. The read chunk may also be zero, which means one frame per request.

Top module: `nor_op_seq`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `done` and `err` are 0.
- R2: Each frame holds `spi_cs_n` low throughout. It sends the opcode first, then (for read 0x03, program 0x02 and erase 0xD8) three address bytes with the most significant byte first. Bits go out MSB first in SPI mode 0: `spi_mosi` changes only while `spi_sck` is low, `spi_miso` is sampled on the rising edge, and `spi_sck` idles low while `spi_cs_n` is high.
- R3: A read (`req_op` 0) is issued as 0x03 frames of RD_CHUNK bytes each, with a shorter last frame, or as one frame when RD_CHUNK is 0. It uses no write-enable or status frames. Each received byte appears on `rd_data` with `rd_valid`, in address order.
- R4: A program request (`req_op` 1) is issued page by page. Each page gets a 0x06 frame, then a 0x02 frame whose PAGE_BYTES data bytes are taken from `wr_data` when `wr_valid` and `wr_ready` are both 1, then 0x05 status frames until status bit 0 reads 0. The next page starts at the address PAGE_BYTES higher.
- R5: An erase request (`req_op` 2) is issued sector by sector. Each sector gets a 0x06 frame, a 0x04-free 0xD8 frame, then 0x05 polling with at least POLL_GAP idle cycles between status frames. The address then advances by SECT_BYTES.
- R6: A request is refused if any of these holds: an erase whose address or length is not a multiple of SECT_BYTES; a program whose address or length is not a multiple of PAGE_BYTES; address plus length greater than DEV_BYTES; or `req_op` 3. A refused request raises `done` and `err` in the cycle after acceptance, and no frame is sent.
- R7: If MAX_POLLS status frames after one program or erase command all report busy, a 0x04 write-disable frame is sent and the request ends with `done` and `err`. Reading not busy on the last allowed poll counts as success.
- R8: Between two frames `spi_cs_n` stays high for at least two clock cycles.
- R9: A request with length 0 ends with `done` and no `err`, and sends no frame.
- R10: `done` lasts exactly one cycle, `err` is only ever 1 together with `done`, and `req_ready` is 1 only while no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte taken when valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data byte strobe |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request refused or timed out, with done |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The delicate cycle is the one where the poll limit is reached at the same moment the flash reports its final status: on that last allowed poll the block must either accept a ready status as success or switch to the write-disable abort path. The bench provokes both outcomes with the same erase request. It sets the flash model's busy count to exactly one less than the limit, and then to exactly the limit. It judges each run by the decoded frame sequence, which must end in a status frame in the first case and a 0x04 frame in the second, and by the `err` flag at `done`.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRDI  = 8'h04;
    localparam logic [7:0] CMD_RDSR  = 8'h05;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_ERASE = 8'hD8;
    localparam int STAT_BUSY_BIT = 0;

    typedef enum logic [2:0] {
        S_IDLE, S_WREN, S_CMD, S_POLL, S_PWAIT, S_WRDI
    } seq_e;

    // opcode, whether a 3-byte address follows, whether the data phase transmits
    typedef struct packed {
        logic [7:0] opcode;
        logic       addr_en;
        logic       tx_data;
    } frame_t;

    function automatic frame_t mk_frame(logic [7:0] opc, logic a_en, logic tx);
        frame_t f;
        f.opcode  = opc;
        f.addr_en = a_en;
        f.tx_data = tx;
        return f;
    endfunction

endpackage

// File: rtl/nor_spi_byte.sv
module nor_spi_byte #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       fin
);
    localparam int CW = $clog2(HALF + 1);

    logic          active;
    logic [CW-1:0] tick;
    logic [2:0]    bitn;
    logic [7:0]    sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            tick   <= '0;
            bitn   <= '0;
            sr     <= '0;
            rx     <= '0;
            sck    <= 1'b0;
            mosi   <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sr     <= tx;
                    mosi   <= tx[7];
                    tick   <= '0;
                    bitn   <= '0;
                end
            end else if (tick == CW'(HALF - 1)) begin
                tick <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sr   <= {sr[6:0], 1'b0};
                        mosi <= sr[6];
                    end
                end
            end else begin
                tick <= tick + CW'(1);
            end
        end
    end
endmodule

// File: rtl/nor_frame.sv
module nor_frame import nor_seq_pkg::*; #(
    parameter int LW   = 25,
    parameter int HALF = 2,
    parameter int GAP  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  frame_t        desc,
    input  logic [23:0]   addr,
    input  logic [LW-1:0] cnt,
    input  logic [7:0]    wr_data,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic [7:0]    rx_byte,
    output logic          rx_stb,
    output logic          fin,
    output logic          cs_n,
    output logic          sck,
    output logic          mosi,
    input  logic          miso
);
    localparam int GW = $clog2(GAP + 1);

    typedef enum logic [1:0] {F_IDLE, F_LOAD, F_SHIFT, F_GAP} fst_e;

    fst_e          st;
    frame_t        d;
    logic [23:0]   a;
    logic [LW-1:0] left;
    logic [2:0]    hidx;
    logic [GW-1:0] gcnt;
    logic [2:0]    hn;
    logic          in_hdr, last_byte, b_start, b_fin;
    logic [7:0]    b_tx, b_rx;

    always_comb begin
        hn        = d.addr_en ? 3'd4 : 3'd1;
        in_hdr    = hidx < hn;
        last_byte = in_hdr ? ((hidx == hn - 3'd1) && (left == '0)) : (left == LW'(1));
        unique case (hidx)
            3'd0:    b_tx = d.opcode;
            3'd1:    b_tx = a[23:16];
            3'd2:    b_tx = a[15:8];
            3'd3:    b_tx = a[7:0];
            default: b_tx = d.tx_data ? wr_data : 8'h00;
        endcase
        wr_ready = (st == F_LOAD) && !in_hdr && d.tx_data;
        b_start  = (st == F_LOAD) && (in_hdr || !d.tx_data || wr_valid);
    end

    nor_spi_byte #(.HALF(HALF)) u_byte (
        .clk(clk), .rst(rst), .start(b_start), .tx(b_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .rx(b_rx), .fin(b_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= F_IDLE;
            d       <= '0;
            a       <= '0;
            left    <= '0;
            hidx    <= '0;
            gcnt    <= '0;
            cs_n    <= 1'b1;
            fin     <= 1'b0;
            rx_stb  <= 1'b0;
            rx_byte <= '0;
        end else begin
            fin    <= 1'b0;
            rx_stb <= 1'b0;
            unique case (st)
                F_IDLE: if (start) begin
                    d    <= desc;
                    a    <= addr;
                    left <= cnt;
                    hidx <= '0;
                    cs_n <= 1'b0;
                    st   <= F_LOAD;
                end
                F_LOAD: if (b_start) st <= F_SHIFT;
                F_SHIFT: if (b_fin) begin
                    if (in_hdr) begin
                        hidx <= hidx + 3'd1;
                    end else begin
                        left <= left - LW'(1);
                        if (!d.tx_data) begin
                            rx_stb  <= 1'b1;
                            rx_byte <= b_rx;
                        end
                    end
                    if (last_byte) begin
                        cs_n <= 1'b1;
                        gcnt <= '0;
                        st   <= F_GAP;
                    end else begin
                        st <= F_LOAD;
                    end
                end
                F_GAP: if (gcnt == GW'(GAP - 1)) begin
                    fin <= 1'b1;
                    st  <= F_IDLE;
                end else begin
                    gcnt <= gcnt + GW'(1);
                end
                default: st <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nor_req_check.sv
module nor_req_check import nor_seq_pkg::*; #(
    parameter int ADDR_W     = 24,
    parameter int DEV_BYTES  = 256,
    parameter int SECT_BYTES = 64,
    parameter int PAGE_BYTES = 16
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   len,
    output logic              bad
);
    localparam int LW = ADDR_W + 1;

    logic [LW:0]   end_sum;
    logic [LW-1:0] both;
    logic          oob, sect_mis, page_mis;

    always_comb begin
        end_sum  = (LW+1)'(addr) + (LW+1)'(len);
        oob      = end_sum > (LW+1)'(DEV_BYTES);
        both     = LW'(addr) | len;
        sect_mis = (both & LW'(SECT_BYTES - 1)) != '0;
        page_mis = (both & LW'(PAGE_BYTES - 1)) != '0;
        case (op)
            OP_READ:  bad = oob;
            OP_PROG:  bad = oob || page_mis;
            OP_ERASE: bad = oob || sect_mis;
            default:  bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/nor_op_seq.sv
module nor_op_seq import nor_seq_pkg::*; #(
    parameter int ADDR_W     = 24,
    parameter int DEV_BYTES  = 256,
    parameter int SECT_BYTES = 64,
    parameter int PAGE_BYTES = 16,
    parameter int RD_CHUNK   = 8,
    parameter int SCK_HALF   = 2,
    parameter int CS_GAP     = 2,
    parameter int POLL_GAP   = 8,
    parameter int MAX_POLLS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W:0]   req_len,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int LW  = ADDR_W + 1;
    localparam int PCW = $clog2(MAX_POLLS + 1);
    localparam int WCW = $clog2(POLL_GAP + 2);
    localparam logic [LW-1:0] SECT_L = LW'(SECT_BYTES);
    localparam logic [LW-1:0] PAGE_L = LW'(PAGE_BYTES);

    seq_e              st;
    op_e               op;
    logic [ADDR_W-1:0] cur;
    logic [LW-1:0]     left, chunk, rd_chunk, fcnt;
    logic [PCW-1:0]    polls;
    logic [WCW-1:0]    wcnt;
    logic              stat_busy, fr_start, fr_fin, fr_rx_stb, req_bad, last_chunk;
    logic [7:0]        fr_rx_byte;
    frame_t            fdesc;

    nor_req_check #(
        .ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES),
        .SECT_BYTES(SECT_BYTES), .PAGE_BYTES(PAGE_BYTES)
    ) u_chk_req (
        .op(op_e'(req_op)), .addr(req_addr), .len(req_len), .bad(req_bad)
    );

    generate
        if (RD_CHUNK == 0) begin : g_rd_whole
            assign rd_chunk = left;
        end else begin : g_rd_split
            assign rd_chunk = (left < LW'(RD_CHUNK)) ? left : LW'(RD_CHUNK);
        end
    endgenerate

    always_comb begin
        case (op)
            OP_PROG:  chunk = PAGE_L;
            OP_ERASE: chunk = SECT_L;
            default:  chunk = rd_chunk;
        endcase
        last_chunk = (left == chunk);
        fdesc = mk_frame(CMD_WREN, 1'b0, 1'b0);
        fcnt  = '0;
        case (st)
            S_CMD: begin
                case (op)
                    OP_PROG:  begin fdesc = mk_frame(CMD_PROG, 1'b1, 1'b1); fcnt = chunk; end
                    OP_ERASE: fdesc = mk_frame(CMD_ERASE, 1'b1, 1'b0);
                    default:  begin fdesc = mk_frame(CMD_READ, 1'b1, 1'b0); fcnt = chunk; end
                endcase
            end
            S_POLL: begin fdesc = mk_frame(CMD_RDSR, 1'b0, 1'b0); fcnt = LW'(1); end
            S_WRDI: fdesc = mk_frame(CMD_WRDI, 1'b0, 1'b0);
            default: ;
        endcase
    end

    nor_frame #(.LW(LW), .HALF(SCK_HALF), .GAP(CS_GAP)) u_frame (
        .clk(clk), .rst(rst), .start(fr_start), .desc(fdesc),
        .addr(24'(cur)), .cnt(fcnt),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rx_byte(fr_rx_byte), .rx_stb(fr_rx_stb), .fin(fr_fin),
        .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

    assign req_ready = (st == S_IDLE);
    assign rd_valid  = fr_rx_stb && (st == S_CMD);
    assign rd_data   = fr_rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            op        <= OP_READ;
            cur       <= '0;
            left      <= '0;
            polls     <= '0;
            wcnt      <= '0;
            stat_busy <= 1'b0;
            fr_start  <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            fr_start <= 1'b0;
            if (fr_rx_stb && st == S_POLL) stat_busy <= fr_rx_byte[STAT_BUSY_BIT];
            unique case (st)
                S_IDLE: if (req_valid) begin
                    op    <= op_e'(req_op);
                    cur   <= req_addr;
                    left  <= req_len;
                    polls <= '0;
                    if (req_bad) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else if (req_len == '0) begin
                        done <= 1'b1;
                    end else begin
                        st       <= (op_e'(req_op) == OP_READ) ? S_CMD : S_WREN;
                        fr_start <= 1'b1;
                    end
                end
                S_WREN: if (fr_fin) begin
                    st       <= S_CMD;
                    fr_start <= 1'b1;
                end
                S_CMD: if (fr_fin) begin
                    if (op == OP_READ) begin
                        cur  <= cur + ADDR_W'(chunk);
                        left <= left - chunk;
                        if (last_chunk) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                        end else begin
                            fr_start <= 1'b1;
                        end
                    end else begin
                        st       <= S_POLL;
                        polls    <= '0;
                        fr_start <= 1'b1;
                    end
                end
                S_POLL: if (fr_fin) begin
                    if (!stat_busy) begin
                        cur  <= cur + ADDR_W'(chunk);
                        left <= left - chunk;
                        if (last_chunk) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                        end else begin
                            st       <= S_WREN;
                            fr_start <= 1'b1;
                        end
                    end else if (int'(polls) >= MAX_POLLS - 1) begin
                        st       <= S_WRDI;
                        fr_start <= 1'b1;
                    end else begin
                        polls <= polls + PCW'(1);
                        if (op == OP_ERASE && POLL_GAP > 0) begin
                            st   <= S_PWAIT;
                            wcnt <= '0;
                        end else begin
                            fr_start <= 1'b1;
                        end
                    end
                end
                S_PWAIT: if (int'(wcnt) >= POLL_GAP - 1) begin
                    st       <= S_POLL;
                    fr_start <= 1'b1;
                end else begin
                    wcnt <= wcnt + WCW'(1);
                end
                S_WRDI: if (fr_fin) begin
                    st   <= S_IDLE;
                    done <= 1'b1;
                    err  <= 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nor_op_seq_chk.sv
module nor_op_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic wr_ready,
    input logic rd_valid,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);
    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> spi_cs_n);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> spi_cs_n);

    // R4
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !spi_cs_n);

    // R3
    rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !req_ready);
endmodule

bind nor_op_seq nor_op_seq_chk u_seq_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .done(done), .err(err),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/nor_op_seq_test.sv
`timescale 1ns/1ps
module nor_op_seq_test;
    localparam int MAXP = 4;
    localparam int PGAP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [24:0] req_len = '0;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid, done, err;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    nor_op_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    typedef struct { int opc; int addr; int n; int t0; int t1; } fr_t;
    fr_t got_q[$];
    fr_t exp_q[$];
    int  data_q[$];
    int  rd_q[$];

    // flash model
    int          bitc = 0, bidx = 0, busy_left = 0, busy_load = 0, t_open = 0;
    logic [7:0]  sh = '0, opc = '0, obyte;
    logic [23:0] fa = '0;
    logic [7:0]  wr_cnt = '0;

    function automatic logic [7:0] mem_b(int a);
        return 8'(a) ^ 8'hA5;
    endfunction

    always @* begin
        if (opc == 8'h05 && bidx >= 1) obyte = {7'b0, busy_left > 0};
        else if (opc == 8'h03 && bidx >= 4) obyte = mem_b(int'(fa) + bidx - 4);
        else obyte = 8'h00;
    end
    assign spi_miso = obyte[7 - (bitc & 7)];

    always @(negedge spi_cs_n) begin
        bitc = 0; bidx = 0; t_open = cyc;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        sh = {sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (bidx == 0) opc = sh;
            else if (bidx <= 3) fa = {fa[15:0], sh};
            else if (opc == 8'h02) data_q.push_back(int'(sh));
            bidx++;
        end
    end
    always @(posedge spi_cs_n) if (!rst) begin
        fr_t f;
        f.opc = int'(opc); f.addr = int'(fa); f.n = bidx; f.t0 = t_open; f.t1 = cyc;
        got_q.push_back(f);
        if (opc == 8'h02 || opc == 8'hD8) busy_left = busy_load;
        else if (opc == 8'h05 && busy_left > 0) busy_left--;
    end

    assign wr_data = wr_cnt;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 8'd1;
    end
    always @(negedge clk) if (rd_valid) rd_q.push_back(int'(rd_data));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference: bus idle rules and done/err relation
    logic prev_sck = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) if (!rst) begin
        if (spi_cs_n && spi_sck) chk(0, "R2 sck idle", spi_sck, 0);
        if (!spi_cs_n && spi_sck && prev_sck && spi_mosi != prev_mosi)
            chk(0, "R2 mosi hold", spi_mosi, prev_mosi);
        if (err && !done) chk(0, "R10 err without done", done, 1);
        if (req_ready && !spi_cs_n) chk(0, "R10 ready in frame", spi_cs_n, 1);
        prev_sck = spi_sck; prev_mosi = spi_mosi;
    end

    task automatic exp_fr(input int o, input int a, input int n);
        fr_t f;
        f.opc = o; f.addr = a; f.n = n; f.t0 = 0; f.t1 = 0;
        exp_q.push_back(f);
    endtask

    int lat;
    logic got_err, pulse_ok;
    logic [7:0] wr0;

    task automatic do_req(input logic [1:0] o, input int a, input int l, input int bl);
        got_q.delete(); exp_q.delete(); data_q.delete(); rd_q.delete();
        busy_load = bl; wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_op = o; req_addr = a[23:0]; req_len = l[24:0];
        @(negedge clk);
        req_valid = 1'b0; lat = 0;
        while (!done && lat < 20000) begin @(negedge clk); lat++; end
        got_err = err;
        @(negedge clk);
        pulse_ok = !done;
    endtask

    task automatic cmp_frames(input string req);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        foreach (exp_q[i]) if (i < got_q.size()) begin
            longint ga = (exp_q[i].n >= 4) ? got_q[i].addr : 0;
            chk(got_q[i].opc == exp_q[i].opc && ga == exp_q[i].addr && got_q[i].n == exp_q[i].n,
                req, (longint'(got_q[i].opc) << 40) | (ga << 16) | got_q[i].n,
                (longint'(exp_q[i].opc) << 40) | (longint'(exp_q[i].addr) << 16) | exp_q[i].n);
        end
    endtask

    task automatic chk_gaps(input string req);
        for (int i = 1; i < got_q.size(); i++)
            chk(got_q[i].t0 - got_q[i-1].t1 >= 2, req, got_q[i].t0 - got_q[i-1].t1, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 bus idle", {spi_cs_n, spi_sck}, 2'b10);
        chk(req_ready == 1'b1 && done == 1'b0 && err == 1'b0, "R1 handshake idle",
            {req_ready, done, err}, 3'b100);

        // R3 read split in 8-byte chunks, R2 framing
        do_req(2'd0, 'h10, 20, 0);
        exp_fr(3, 'h10, 12); exp_fr(3, 'h18, 12); exp_fr(3, 'h20, 8);
        cmp_frames("R3 read frames (R2)");
        chk(got_err == 0, "R3 read err", got_err, 0);
        chk(rd_q.size() == 20, "R3 read count", rd_q.size(), 20);
        foreach (rd_q[i]) chk(rd_q[i] == int'(mem_b('h10 + i)), "R3 read data", rd_q[i], mem_b('h10 + i));
        chk(pulse_ok, "R10 done one cycle", !pulse_ok, 0);
        chk_gaps("R8 cs gap read");

        // R4 program two pages, two busy polls each
        do_req(2'd1, 'h40, 32, 2);
        for (int p = 0; p < 2; p++) begin
            exp_fr(6, 0, 1); exp_fr(2, 'h40 + 16 * p, 20);
            for (int k = 0; k < 3; k++) exp_fr(5, 0, 2);
        end
        cmp_frames("R4 program frames");
        chk(got_err == 0, "R4 program err", got_err, 0);
        chk(data_q.size() == 32, "R4 data count", data_q.size(), 32);
        foreach (data_q[i]) chk(data_q[i] == int'(8'(wr0 + 8'(i))), "R4 data", data_q[i], 8'(wr0 + 8'(i)));
        for (int i = 1; i < got_q.size(); i++)
            if (got_q[i].opc == 5 && got_q[i-1].opc == 5)
                chk(got_q[i].t0 - got_q[i-1].t1 < PGAP, "R4 program polls back to back",
                    got_q[i].t0 - got_q[i-1].t1, PGAP);
        chk_gaps("R8 cs gap program");

        // R5 erase two sectors up to the device end
        do_req(2'd2, 'h80, 128, 1);
        for (int s = 0; s < 2; s++) begin
            exp_fr(6, 0, 1); exp_fr('hD8, 'h80 + 64 * s, 4);
            exp_fr(5, 0, 2); exp_fr(5, 0, 2);
        end
        cmp_frames("R5 erase frames");
        chk(got_err == 0, "R5 erase err", got_err, 0);
        for (int i = 1; i < got_q.size(); i++)
            if (got_q[i].opc == 5 && got_q[i-1].opc == 5)
                chk(got_q[i].t0 - got_q[i-1].t1 >= PGAP, "R5 poll interval",
                    got_q[i].t0 - got_q[i-1].t1, PGAP);
        chk_gaps("R8 cs gap erase");

        // R6 refusals: no frame, done+err the cycle after acceptance
        do_req(2'd2, 'h20, 64, 0);
        chk(got_err && lat == 0 && got_q.size() == 0, "R6 erase misaligned", {got_err, 8'(lat), 8'(got_q.size())}, 17'h10000);
        do_req(2'd1, 'h48, 16, 0);
        chk(got_err && lat == 0 && got_q.size() == 0, "R6 program misaligned", {got_err, 8'(lat), 8'(got_q.size())}, 17'h10000);
        do_req(2'd0, 250, 10, 0);
        chk(got_err && lat == 0 && got_q.size() == 0, "R6 read out of range", {got_err, 8'(lat), 8'(got_q.size())}, 17'h10000);
        do_req(2'd3, 0, 16, 0);
        chk(got_err && lat == 0 && got_q.size() == 0, "R6 reserved op", {got_err, 8'(lat), 8'(got_q.size())}, 17'h10000);

        // R7 ready on the last allowed poll
        do_req(2'd2, 0, 64, MAXP - 1);
        exp_fr(6, 0, 1); exp_fr('hD8, 0, 4);
        for (int k = 0; k < MAXP; k++) exp_fr(5, 0, 2);
        cmp_frames("R7 last poll success frames");
        chk(got_err == 0, "R7 last poll success err", got_err, 0);

        // R7 still busy on the last allowed poll
        do_req(2'd2, 0, 64, MAXP);
        exp_fr(6, 0, 1); exp_fr('hD8, 0, 4);
        for (int k = 0; k < MAXP; k++) exp_fr(5, 0, 2);
        exp_fr(4, 0, 1);
        cmp_frames("R7 timeout frames");
        chk(got_err == 1, "R7 timeout err", got_err, 1);

        // R9 zero length
        do_req(2'd0, 0, 0, 0);
        chk(!got_err && got_q.size() == 0 && lat == 0, "R9 zero length", {got_err, 8'(got_q.size())}, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule